// File: doc/BRIEF.md
# Host-Word to ATA Task-File Register Bridge

This block sits between a 32-bit host register bus that carries per-byte lane enables and a 16-bit port into an ATA device's task file. Two windows are decoded: the command block (window 0) and the control block (window 1). Each host request gives a word offset and a four-bit lane mask. The bridge turns it into zero, one or two 16-bit register strobes toward the device. It picks the register index from the offset and the active lanes, and moves data between host lanes and the 16-bit device word. A full-width access to the data register at offset 0 becomes two back-to-back 16-bit transfers, so the host can move 32 bits per access.

A mode input selects a 16-bit host view. In that view only lanes 15:0 count. A byte access on lane 15:8 reaches the odd register of the pair. A full 16-bit command-window access at offset 1 is folded onto the data register and flagged as misuse.

The host side is a request/response pair with valid/ready. A request is taken when `req_valid` and `req_ready` are both high. Only one request is in flight at a time, so `req_ready` stays low from acceptance until the response is taken. A response is offered with `rsp_valid` and held, data unchanged, until `rsp_ready` is high at a clock edge. Every accepted request, read or write, gets exactly one response, and write responses carry zero. The device side is a plain strobe: on each cycle with `dev_stb` high the device performs one access and must return read data combinationally on `dev_rdata` in that cycle.

Top module: `ata_reg_bridge32`

## Requirements
- R1: After reset `req_ready` is high, `rsp_valid` is low and no device strobe is issued.
- R2: In 32-bit mode, a window-0 access with lanes 15:0 enabled and lanes 31:16 idle strobes register index 2*offset with `dev_be` = be[1:0]. Write data comes from host bits 15:0, and read data returns in bits 15:0.
- R3: In 32-bit mode, a window-0 access with only lanes 31:16 enabled strobes index 2*offset+1 with `dev_be` = be[3:2]. Data moves between host bits 31:16 and the device word.
- R4: In 32-bit mode, a window-0 access at offset 0 that touches both 16-bit halves gives two strobes in consecutive cycles, both to index 0. The first beat carries bits 15:0 and the second bits 31:16. A read response holds both halves.
- R5: In 32-bit mode, a window-0 access at a nonzero offset that touches both halves gives only the index 2*offset strobe. The upper lanes are dropped and read back as zero.
- R6: In 32-bit mode, a window-1 read with any of lanes 15:0 enabled strobes index 2*offset. Otherwise, with lane 23:16 (be[2]) enabled, it strobes 2*offset+1 and returns the data in bits 31:16. A window-1 read with only be[3] set gives no strobe.
- R7: In 32-bit mode, a window-1 write with be[0] set strobes index 2*offset. Otherwise, with be[2] set, it strobes 2*offset+1 with data from bits 31:16. A window-1 write with only be[1] set gives no strobe.
- R8: In 16-bit mode, a request with be[1:0] = 2'b10 strobes index 2*offset+1 with `dev_be` = 2'b01. The host byte 15:8 travels on device bits 7:0, and read data returns in host bits 15:8.
- R9: In 16-bit mode, a window-0 request with be[1:0] = 2'b11 at offset 1 strobes index 0, with `misuse` high in that strobe cycle. `misuse` is never high otherwise.
- R10: Response lanes whose byte enable is off read as zero. In 16-bit mode lanes 31:16 are ignored. A request whose effective lanes are all off gives no strobe but still gets a response with zero data.
- R11: Only one request is in flight at a time. No strobe occurs while `req_ready` or `rsp_valid` is high. A response held by low `rsp_ready` keeps its data stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode16 | input | 1 | 1 selects the 16-bit host view; sampled at request acceptance |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | 0 = command window, 1 = control window |
| req_off | input | OFF_W | Word offset within the window |
| req_be | input | 4 | Host byte-lane enables, bit n covers bits 8n+7:8n |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Assembled read data, zero for writes |
| dev_stb | output | 1 | Device register access strobe |
| dev_we | output | 1 | Strobe is a write |
| dev_win | output | 1 | Window of the strobe |
| dev_idx | output | OFF_W+1 | Register index of the strobe |
| dev_be | output | 2 | Device byte enables |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data, valid in the strobe cycle |
| misuse | output | 1 | Pulses with a redirected 16-bit offset-1 strobe |

## Verification
Response back-pressure and a waiting next request can meet in the same cycle. For a two-beat transfer there is a further overlap: the host can already present the next request while the second beat is still on the device port. The bench holds `rsp_ready` low in a repeating pattern while the driver keeps `req_valid` high with the next request. It judges the result in two ways. The strobe monitor must see no beat that the expected queue does not hold. The held response data must not change between cycles until the handshake.

// File: rtl/atab_pkg.sv
package atab_pkg;
  localparam int HOST_W  = 32;
  localparam int DEV_W   = 16;
  localparam int HOST_BE = HOST_W / 8;
  localparam int DEV_BE  = DEV_W / 8;

  // where a beat's device word sits on the host word
  typedef enum logic [1:0] {
    LN_LO  = 2'd0,   // host 15:0
    LN_HI  = 2'd1,   // host 31:16
    LN_UP8 = 2'd2    // host 15:8 carried on device 7:0
  } lane_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_BEAT0 = 2'd1,
    SQ_BEAT1 = 2'd2,
    SQ_RESP  = 2'd3
  } seq_e;

  localparam logic WIN_CMD = 1'b0;
  localparam logic WIN_CTL = 1'b1;
endpackage

// File: rtl/atab_decode.sv
module atab_decode
  import atab_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic                   mode16,
  input  logic                   win,
  input  logic                   wr,
  input  logic [OFF_W-1:0]       off,
  input  logic [HOST_BE-1:0]     be,
  output logic [1:0]             nbeats,
  output logic [OFF_W:0]         idx0,
  output lane_e                  lane0,
  output logic [DEV_BE-1:0]      be0,
  output logic [OFF_W:0]         idx1,
  output logic [DEV_BE-1:0]      be1,
  output logic                   mis
);
  localparam int IDX_W = OFF_W + 1;

  logic [IDX_W-1:0] even_idx;
  logic [IDX_W-1:0] odd_idx;
  logic             lo_any;
  logic             hi_any;
  logic             off_zero;
  logic             off_one;

  assign even_idx = {off, 1'b0};
  assign odd_idx  = {off, 1'b1};
  assign lo_any   = |be[DEV_BE-1:0];
  assign hi_any   = |be[HOST_BE-1:DEV_BE];
  assign off_zero = (off == '0);
  assign off_one  = (off == OFF_W'(1));

  always_comb begin
    nbeats = 2'd0;
    idx0   = even_idx;
    lane0  = LN_LO;
    be0    = be[DEV_BE-1:0];
    idx1   = '0;
    be1    = be[HOST_BE-1:DEV_BE];
    mis    = 1'b0;
    if (mode16) begin
      unique case (be[DEV_BE-1:0])
        2'b11: begin
          nbeats = 2'd1;
          if (win == WIN_CMD && off_one) begin
            idx0 = '0;
            mis  = 1'b1;
          end
        end
        2'b01: nbeats = 2'd1;
        2'b10: begin
          nbeats = 2'd1;
          idx0   = odd_idx;
          lane0  = LN_UP8;
          be0    = 2'b01;
        end
        default: nbeats = 2'd0;
      endcase
    end else if (win == WIN_CMD) begin
      if (lo_any) begin
        nbeats = (off_zero && hi_any) ? 2'd2 : 2'd1;
      end else if (hi_any) begin
        nbeats = 2'd1;
        idx0   = odd_idx;
        lane0  = LN_HI;
        be0    = be[HOST_BE-1:DEV_BE];
      end
    end else begin
      if (wr ? be[0] : lo_any) begin
        nbeats = 2'd1;
      end else if (be[2]) begin
        nbeats = 2'd1;
        idx0   = odd_idx;
        lane0  = LN_HI;
        be0    = be[HOST_BE-1:DEV_BE];
      end
    end
  end
endmodule

// File: rtl/atab_steer.sv
module atab_steer
  import atab_pkg::*;
(
  input  lane_e               lane,
  input  logic [DEV_BE-1:0]   be,
  input  logic [HOST_W-1:0]   host_wdata,
  input  logic [DEV_W-1:0]    dev_rdata,
  output logic [DEV_W-1:0]    dev_wdata,
  output logic [HOST_W-1:0]   place
);
  logic [DEV_W-1:0] rd_masked;

  genvar b;
  generate
    for (b = 0; b < DEV_BE; b++) begin : g_lane
      assign rd_masked[b*8 +: 8] = be[b] ? dev_rdata[b*8 +: 8] : 8'h00;
    end
  endgenerate

  always_comb begin
    dev_wdata = host_wdata[DEV_W-1:0];
    place     = '0;
    unique case (lane)
      LN_HI: begin
        dev_wdata = host_wdata[HOST_W-1:DEV_W];
        place     = {rd_masked, {DEV_W{1'b0}}};
      end
      LN_UP8: begin
        dev_wdata = {8'h00, host_wdata[15:8]};
        place     = {{DEV_W{1'b0}}, rd_masked[7:0], 8'h00};
      end
      default: begin
        dev_wdata = host_wdata[DEV_W-1:0];
        place     = {{DEV_W{1'b0}}, rd_masked};
      end
    endcase
  end
endmodule

// File: rtl/atab_seq.sv
module atab_seq
  import atab_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_win,
  input  logic [HOST_W-1:0]    req_wdata,
  input  logic [1:0]           d_nbeats,
  input  logic [OFF_W:0]       d_idx0,
  input  lane_e                d_lane0,
  input  logic [DEV_BE-1:0]    d_be0,
  input  logic [OFF_W:0]       d_idx1,
  input  logic [DEV_BE-1:0]    d_be1,
  input  logic                 d_mis,
  output logic                 stb,
  output logic                 we,
  output logic                 win,
  output logic [OFF_W:0]       idx,
  output lane_e                cur_lane,
  output logic [DEV_BE-1:0]    cur_be,
  output logic [HOST_W-1:0]    wdata_q,
  output logic                 mis_o,
  input  logic [HOST_W-1:0]    place,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [HOST_W-1:0]    rsp_rdata
);
  localparam int IDX_W = OFF_W + 1;

  seq_e              state;
  logic [1:0]        nb_q;
  logic [IDX_W-1:0]  idx0_q;
  logic [IDX_W-1:0]  idx1_q;
  lane_e             lane0_q;
  logic [DEV_BE-1:0] be0_q;
  logic [DEV_BE-1:0] be1_q;
  logic              mis_q;
  logic              we_q;
  logic              win_q;
  logic [HOST_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      nb_q    <= '0;
      idx0_q  <= '0;
      idx1_q  <= '0;
      lane0_q <= LN_LO;
      be0_q   <= '0;
      be1_q   <= '0;
      mis_q   <= 1'b0;
      we_q    <= 1'b0;
      win_q   <= 1'b0;
      wdata_q <= '0;
      hold_q  <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (req_valid) begin
            nb_q    <= d_nbeats;
            idx0_q  <= d_idx0;
            idx1_q  <= d_idx1;
            lane0_q <= d_lane0;
            be0_q   <= d_be0;
            be1_q   <= d_be1;
            mis_q   <= d_mis;
            we_q    <= req_write;
            win_q   <= req_win;
            wdata_q <= req_wdata;
            hold_q  <= '0;
            state   <= (d_nbeats == 2'd0) ? SQ_RESP : SQ_BEAT0;
          end
        end
        SQ_BEAT0: begin
          if (!we_q) hold_q <= hold_q | place;
          state <= (nb_q == 2'd2) ? SQ_BEAT1 : SQ_RESP;
        end
        SQ_BEAT1: begin
          if (!we_q) hold_q <= hold_q | place;
          state <= SQ_RESP;
        end
        default: begin
          if (rsp_ready) state <= SQ_IDLE;
        end
      endcase
    end
  end

  assign req_ready = (state == SQ_IDLE);
  assign stb       = (state == SQ_BEAT0) || (state == SQ_BEAT1);
  assign we        = we_q;
  assign win       = win_q;
  assign idx       = (state == SQ_BEAT1) ? idx1_q : idx0_q;
  assign cur_lane  = (state == SQ_BEAT1) ? LN_HI : lane0_q;
  assign cur_be    = (state == SQ_BEAT1) ? be1_q : be0_q;
  assign mis_o     = (state == SQ_BEAT0) && mis_q;
  assign rsp_valid = (state == SQ_RESP);
  assign rsp_rdata = hold_q;
endmodule

// File: rtl/ata_reg_bridge32.sv
module ata_reg_bridge32
  import atab_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_mode16,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_win,
  input  logic [OFF_W-1:0]    req_off,
  input  logic [3:0]          req_be,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [31:0]         rsp_rdata,
  output logic                dev_stb,
  output logic                dev_we,
  output logic                dev_win,
  output logic [OFF_W:0]      dev_idx,
  output logic [1:0]          dev_be,
  output logic [15:0]         dev_wdata,
  input  logic [15:0]         dev_rdata,
  output logic                misuse
);
  logic [1:0]        d_nbeats;
  logic [OFF_W:0]    d_idx0;
  logic [OFF_W:0]    d_idx1;
  lane_e             d_lane0;
  logic [DEV_BE-1:0] d_be0;
  logic [DEV_BE-1:0] d_be1;
  logic              d_mis;
  lane_e             cur_lane;
  logic [HOST_W-1:0] wdata_q;
  logic [HOST_W-1:0] place;

  atab_decode #(.OFF_W(OFF_W)) u_dec (
    .mode16 (host_mode16),
    .win    (req_win),
    .wr     (req_write),
    .off    (req_off),
    .be     (req_be),
    .nbeats (d_nbeats),
    .idx0   (d_idx0),
    .lane0  (d_lane0),
    .be0    (d_be0),
    .idx1   (d_idx1),
    .be1    (d_be1),
    .mis    (d_mis)
  );

  atab_seq #(.OFF_W(OFF_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_win   (req_win),
    .req_wdata (req_wdata),
    .d_nbeats  (d_nbeats),
    .d_idx0    (d_idx0),
    .d_lane0   (d_lane0),
    .d_be0     (d_be0),
    .d_idx1    (d_idx1),
    .d_be1     (d_be1),
    .d_mis     (d_mis),
    .stb       (dev_stb),
    .we        (dev_we),
    .win       (dev_win),
    .idx       (dev_idx),
    .cur_lane  (cur_lane),
    .cur_be    (dev_be),
    .wdata_q   (wdata_q),
    .mis_o     (misuse),
    .place     (place),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
  );

  atab_steer u_steer (
    .lane       (cur_lane),
    .be         (dev_be),
    .host_wdata (wdata_q),
    .dev_rdata  (dev_rdata),
    .dev_wdata  (dev_wdata),
    .place      (place)
  );
endmodule

// File: rtl/atab_chk.sv
module atab_chk #(
  parameter int OFF_W = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [31:0]    rsp_rdata,
  input logic           dev_stb,
  input logic           dev_win,
  input logic [OFF_W:0] dev_idx,
  input logic [1:0]     dev_be,
  input logic           misuse
);
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R11

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R11

  AST_NO_STB_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || rsp_valid) |-> !dev_stb); // R11

  AST_MISUSE_ON_DATA_REG: assert property (@(posedge clk) disable iff (!rst_n)
    misuse |-> dev_stb && !dev_win && (dev_idx == '0)); // R9

  AST_STB_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    dev_stb |-> (dev_be != 2'b00)); // R10
endmodule

bind ata_reg_bridge32 atab_chk #(.OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .dev_stb   (dev_stb),
  .dev_win   (dev_win),
  .dev_idx   (dev_idx),
  .dev_be    (dev_be),
  .misuse    (misuse)
);

// File: tb/tb_ata_reg_bridge32.sv
module tb_ata_reg_bridge32;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_W = 2;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_mode16 = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic req_win = 1'b0;
  logic [OFF_W-1:0] req_off = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic dev_stb, dev_we, dev_win, misuse;
  logic [OFF_W:0] dev_idx;
  logic [1:0] dev_be;
  logic [15:0] dev_wdata;
  logic [15:0] dev_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit holdoff = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_reg_bridge32 #(.OFF_W(OFF_W)) dut (.*);

  // device register model
  logic [15:0] mdl [2][8];
  assign dev_rdata = mdl[dev_win][dev_idx];
  always @(posedge clk)
    if (dev_stb && dev_we) begin
      if (dev_be[0]) mdl[dev_win][dev_idx][7:0]  <= dev_wdata[7:0];
      if (dev_be[1]) mdl[dev_win][dev_idx][15:8] <= dev_wdata[15:8];
    end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_ready <= holdoff ? !(cyc[0] && cyc[2]) && !(cyc[1] && cyc[3]) : 1'b1;
  end

  // expected strobes and responses
  typedef struct packed {
    logic we; logic win; logic [2:0] idx; logic [1:0] be; logic [15:0] wd; logic mis;
  } beat_t;
  beat_t beat_q[$];
  string beat_tag[$];
  logic [31:0] rsp_q[$];
  string rsp_tag[$];
  logic [15:0] shadow [2][8];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic exp_beat(input bit we, input bit win, input int idx, input logic [1:0] be,
                          input logic [15:0] wd, input bit mis, input string tag,
                          output logic [15:0] rv);
    beat_t b;
    b.we = we; b.win = win; b.idx = idx[2:0]; b.be = be; b.wd = wd; b.mis = mis;
    beat_q.push_back(b);
    beat_tag.push_back(tag);
    rv = shadow[win][idx];
    rv[7:0]  = be[0] ? rv[7:0]  : 8'h00;
    rv[15:8] = be[1] ? rv[15:8] : 8'h00;
    if (we) begin
      if (be[0]) shadow[win][idx][7:0]  = wd[7:0];
      if (be[1]) shadow[win][idx][15:8] = wd[15:8];
    end
  endtask

  // driver: reference mapping from the requirements, then the handshake
  task automatic issue(input bit m16, input bit win, input bit wr, input int off,
                       input logic [3:0] be, input logic [31:0] wd, input string tag);
    logic [31:0] e;
    logic [15:0] rv;
    e = '0;
    if (m16) begin
      case (be[1:0])
        2'b11: begin
          if (win == 1'b0 && off == 1) exp_beat(wr, win, 0, 2'b11, wd[15:0], 1'b1, tag, rv);
          else exp_beat(wr, win, off*2, 2'b11, wd[15:0], 1'b0, tag, rv);
          e[15:0] = rv;
        end
        2'b01: begin exp_beat(wr, win, off*2, 2'b01, {8'h00, wd[7:0]}, 1'b0, tag, rv); e[7:0] = rv[7:0]; end
        2'b10: begin exp_beat(wr, win, off*2+1, 2'b01, {8'h00, wd[15:8]}, 1'b0, tag, rv); e[15:8] = rv[7:0]; end
        default: ;
      endcase
    end else if (win == 1'b0) begin
      if (|be[1:0]) begin
        exp_beat(wr, win, off*2, be[1:0], wd[15:0], 1'b0, tag, rv); e[15:0] = rv;
        if (off == 0 && |be[3:2]) begin
          exp_beat(wr, win, 0, be[3:2], wd[31:16], 1'b0, tag, rv); e[31:16] = rv;
        end
      end else if (|be[3:2]) begin
        exp_beat(wr, win, off*2+1, be[3:2], wd[31:16], 1'b0, tag, rv); e[31:16] = rv;
      end
    end else begin
      if (wr ? be[0] : |be[1:0]) begin
        exp_beat(wr, win, off*2, be[1:0], wd[15:0], 1'b0, tag, rv); e[15:0] = rv;
      end else if (be[2]) begin
        exp_beat(wr, win, off*2+1, be[3:2], wd[31:16], 1'b0, tag, rv); e[31:16] = rv;
      end
    end
    rsp_q.push_back(wr ? 32'h0 : e);
    rsp_tag.push_back(tag);
    @(negedge clk);
    host_mode16 = m16; req_win = win; req_write = wr;
    req_off = off[OFF_W-1:0]; req_be = be; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitors
  logic [31:0] held_data;
  bit held = 1'b0;
  always @(negedge clk) begin
    if (rst_n && dev_stb) begin
      beat_t b;
      string t;
      if (beat_q.size() == 0) begin
        chk(1'b0, "R11", "unexpected strobe idx", 32'(dev_idx), 32'hx);
      end else begin
        b = beat_q.pop_front();
        t = beat_tag.pop_front();
        chk(dev_we == b.we && dev_win == b.win && dev_idx == b.idx && dev_be == b.be,
            t, "we/win/idx/be", {24'h0, dev_we, dev_win, dev_idx, dev_be},
            {24'h0, b.we, b.win, b.idx, b.be});
        if (b.we) chk(dev_wdata == b.wd, t, "wdata", 32'(dev_wdata), 32'(b.wd));
        chk(misuse == b.mis, b.mis ? t : "R9", "misuse", 32'(misuse), 32'(b.mis));
      end
    end
    if (rst_n && rsp_valid) begin
      if (held) chk(rsp_rdata == held_data, "R11", "held response changed", rsp_rdata, held_data);
      if (rsp_ready) begin
        held = 1'b0;
        if (rsp_q.size() == 0) chk(1'b0, "R11", "unexpected response", rsp_rdata, 32'hx);
        else chk(rsp_rdata == rsp_q[0], rsp_tag[0], "rdata", rsp_rdata, rsp_q[0]);
        if (rsp_q.size() != 0) begin void'(rsp_q.pop_front()); void'(rsp_tag.pop_front()); end
      end else begin
        held = 1'b1;
        held_data = rsp_rdata;
      end
    end
  end

  task automatic run_set();
    // 32-bit command window
    issue(0, 0, 1, 0, 4'b1111, 32'hBEEF_1234, "R4");
    issue(0, 0, 1, 1, 4'b0011, 32'h0000_5A5A, "R2");
    issue(0, 0, 1, 1, 4'b1100, 32'hC3C3_0000, "R3");
    issue(0, 0, 1, 2, 4'b0001, 32'h0000_0077, "R2");
    issue(0, 0, 1, 3, 4'b1000, 32'h9900_0000, "R3");
    issue(0, 0, 1, 1, 4'b1111, 32'h1111_2222, "R5");
    issue(0, 0, 0, 1, 4'b0011, 32'h0, "R2");
    issue(0, 0, 0, 1, 4'b1100, 32'h0, "R3");
    issue(0, 0, 0, 0, 4'b1111, 32'h0, "R4");
    issue(0, 0, 0, 1, 4'b1111, 32'h0, "R5");
    issue(0, 0, 0, 2, 4'b0010, 32'h0, "R10");
    issue(0, 0, 0, 3, 4'b0000, 32'h0, "R10");
    issue(0, 0, 1, 2, 4'b0000, 32'hFFFF_FFFF, "R10");
    // 32-bit control window
    issue(0, 1, 1, 0, 4'b0001, 32'h0000_00A1, "R7");
    issue(0, 1, 1, 1, 4'b0100, 32'h00B2_0000, "R7");
    issue(0, 1, 1, 0, 4'b0010, 32'h0000_EE00, "R7");
    issue(0, 1, 1, 1, 4'b0011, 32'h0000_C4D5, "R7");
    issue(0, 1, 0, 0, 4'b0011, 32'h0, "R6");
    issue(0, 1, 0, 1, 4'b1100, 32'h0, "R6");
    issue(0, 1, 0, 0, 4'b1000, 32'h0, "R6");
    issue(0, 1, 0, 1, 4'b0110, 32'h0, "R6");
    // 16-bit host view
    issue(1, 0, 1, 1, 4'b0011, 32'h0000_7777, "R9");
    issue(1, 0, 0, 1, 4'b0011, 32'h0, "R9");
    issue(1, 0, 1, 1, 4'b0010, 32'h0000_AB00, "R8");
    issue(1, 0, 0, 1, 4'b0010, 32'h0, "R8");
    issue(1, 0, 1, 2, 4'b0001, 32'h0000_0042, "R10");
    issue(1, 0, 1, 2, 4'b1100, 32'h5555_0000, "R10");
    issue(1, 0, 0, 2, 4'b1111, 32'h0, "R10");
    issue(1, 1, 1, 1, 4'b0011, 32'h0000_3C3C, "R9");
    issue(1, 1, 0, 1, 4'b0011, 32'h0, "R9");
  endtask

  initial begin
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 8; i++) begin
        mdl[w][i] = 16'(16'h1000 * w + 16'h0101 * i + 16'h0F00);
        shadow[w][i] = mdl[w][i];
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk(dev_stb == 1'b0, "R1", "dev_stb after reset", 32'(dev_stb), 32'h0);
    run_set();
    holdoff = 1'b1;
    run_set();
    holdoff = 1'b0;
    repeat (20) @(negedge clk);
    chk(beat_q.size() == 0, "R11", "missing strobes", 32'(beat_q.size()), 32'h0);
    chk(rsp_q.size() == 0, "R11", "missing responses", 32'(rsp_q.size()), 32'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog: actual %0d cycles expected fewer", WDOG);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule